// File: doc/BRIEF.md
# NAPOT Address Restriction Checker

This block screens every load or store effective address against a small, fully associative set of address-match entries. Each entry holds one match register and two 128-bit restriction vectors, one for all accesses and one for stores. A match register describes a naturally aligned power-of-two region. Its size exponent S is the run of zero bits that starts at bit 12 and ends at the first one bit. The lowest-numbered entry that matches supplies one bit from each vector, chosen by seven effective-address bits starting at bit 12+S. Those two bits form a restriction code, which decides whether the access may go ahead.

For each request the block also builds a result word for a test instruction. This word lets software branch on a restriction instead of taking a trap. Configuration comes in through a simple write port that addresses one 64-bit register at a time. A lookup gives its result one clock cycle after the request.

Top module: `addr_restrict_check`

## Requirements
- R1: After reset every entry is disabled, rsp_valid is 0, and a lookup reports rsp_hit=0, rsp_code=00, rsp_deny=0 and rsp_test=0.
- R2: A request presented with req_valid=1 is answered on the next clock edge with rsp_valid=1. Cycles without a request give rsp_valid=0 one cycle later. Back-to-back requests give back-to-back answers.
- R3: S is the number of zero bits in the match register counted upward from bit 12 up to the first 1. An entry matches when effective-address bits VAW-1 down to 13+S equal the same match-register bits. Address bits at and above VAW are ignored. An entry with no 1 in bits 63:12 never matches.
- R4: On a match, effective-address bits 18+S down to 12+S give an index 0..127 into both vectors. Indices 0..63 select bits of the low word and 64..127 select bits of the high word. cfg_reg selects the register a write goes to: 0 = match, 1 = access-vector low, 2 = access-vector high, 3 = store-vector low, 4 = store-vector high. A write affects lookups presented after its clock edge.
- R5: rsp_code = {store-vector bit, access-vector bit}. Code 00 allows the access. Code 01 denies loads and stores. Code 10 denies stores only. Code 11 is reserved and denies both. rsp_deny reports the denial for the request's kind (req_is_store).
- R6: The type field is match-register bits 3:0. Type 1 uses only the access vector. Type 2 uses only the store vector. Type 3 uses both. Types 4 and 5 match but always give code 00. Type 0 is disabled.
- R7: The lowest-numbered matching entry decides the result. When no enabled entry matches, the outputs are hit 0, code 00, deny 0 and test word 0.
- R8: On a hit, rsp_test holds effective-address bits 62 down to 12+S in place. Bits 11:4 hold match-register bits 11:4 (the software field in 11:6 and the generation field in 5:4). The remaining low bits are 0, and bit 63 equals rsp_deny.
- R9: A match-register write with a type value of 6 to 15 stores type 0, so that entry is disabled.
- R10: A match register whose bits 63:12 hold only bit 63 matches every address. Its index is effective-address bit 63, and its test word carries no address bits.
- R11: Writes with cfg_entry at or above NUM_ENTRIES, or with cfg_reg 5 to 7, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_entry | input | 4 | Entry number for the write |
| cfg_reg | input | 3 | Register select within the entry |
| cfg_wdata | input | 64 | Write data |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 64 | Effective address to check |
| req_is_store | input | 1 | 1 for a store, 0 for a load |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 1 | An enabled entry matched |
| rsp_code | output | 2 | Restriction code {store bit, access bit} |
| rsp_deny | output | 1 | The access is refused for its kind |
| rsp_test | output | 64 | Test-instruction result word |

## Verification
The checker watches the properties that hold on every cycle:
- the one-cycle answer timing;
- the clean all-zero result on a miss;
- agreement of test bit 63 with the deny flag;
- that code 01 always denies;
- that a load never sees a store-only denial;
- that the priority selector grants at most one entry, and only one that hit.

Only the bench scenarios can show the rest:
- the trailing-zero size decode and the address compare;
- which vector bit a given address picks;
- how each type value masks the vectors;
- coercion of reserved types;
- the layout of the test word;
- that writes aimed outside the entry set are ignored.

// File: rtl/arc_pkg.sv
package arc_pkg;

  localparam int XLEN      = 64;
  localparam int IDX_W     = 4;
  localparam int SUB_BITS  = 7;
  localparam int SUB_COUNT = 1 << SUB_BITS;
  localparam int NAPOT_LSB = 12;

  typedef enum logic [2:0] {
    SEL_MATCH  = 3'd0,
    SEL_ACC_LO = 3'd1,
    SEL_ACC_HI = 3'd2,
    SEL_WR_LO  = 3'd3,
    SEL_WR_HI  = 3'd4
  } cfg_sel_e;

  typedef enum logic [3:0] {
    KIND_OFF      = 4'd0,
    KIND_ACC      = 4'd1,
    KIND_WR       = 4'd2,
    KIND_BOTH     = 4'd3,
    KIND_GEN_MIN  = 4'd4,
    KIND_GEN_TRAP = 4'd5
  } kind_e;

  typedef enum logic [1:0] {
    RC_NONE  = 2'b00,
    RC_ALL   = 2'b01,
    RC_STORE = 2'b10,
    RC_RSVD  = 2'b11
  } rcode_e;

  typedef struct packed {
    logic [XLEN-1:0]      match;
    logic [SUB_COUNT-1:0] acc;
    logic [SUB_COUNT-1:0] wr;
  } entry_t;

endpackage

// File: rtl/arc_entry_bank.sv
module arc_entry_bank
  import arc_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [IDX_W-1:0]              cfg_entry,
  input  logic [2:0]                    cfg_reg,
  input  logic [XLEN-1:0]               cfg_wdata,
  output entry_t [NUM_ENTRIES-1:0]      entries_o
);

  localparam int HALF = SUB_COUNT / 2;

  // Reserved type values are folded to the disabled code on write.
  logic [XLEN-1:0] match_warl;
  always_comb begin
    match_warl = cfg_wdata;
    if (cfg_wdata[3:0] > KIND_GEN_TRAP) match_warl[3:0] = KIND_OFF;
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    entry_t ent_q;
    entry_t ent_d;
    logic   ent_en;
    logic   hit_sel;

    assign hit_sel = cfg_we && (cfg_entry == IDX_W'(e));

    always_comb begin
      ent_d  = ent_q;
      ent_en = 1'b0;
      if (hit_sel) begin
        case (cfg_reg)
          SEL_MATCH:  begin ent_en = 1'b1; ent_d.match         = match_warl; end
          SEL_ACC_LO: begin ent_en = 1'b1; ent_d.acc[HALF-1:0] = cfg_wdata;  end
          SEL_ACC_HI: begin ent_en = 1'b1; ent_d.acc[SUB_COUNT-1:HALF] = cfg_wdata; end
          SEL_WR_LO:  begin ent_en = 1'b1; ent_d.wr[HALF-1:0]  = cfg_wdata;  end
          SEL_WR_HI:  begin ent_en = 1'b1; ent_d.wr[SUB_COUNT-1:HALF] = cfg_wdata; end
          default:    ent_en = 1'b0;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_en) ent_q <= ent_d;
    end

    assign entries_o[e] = ent_q;
  end

endmodule

// File: rtl/arc_entry_match.sv
module arc_entry_match
  import arc_pkg::*;
#(
  parameter int VAW = 48
) (
  input  entry_t          ent,
  input  logic [XLEN-1:0] addr,
  output logic            hit,
  output logic [1:0]      code,
  output logic [XLEN-1:0] test_body
);

  localparam logic [XLEN-1:0] VA_MASK   = {{(XLEN-VAW){1'b0}}, {VAW{1'b1}}};
  localparam logic [XLEN-1:0] TOP_CLEAR = {1'b0, {(XLEN-1){1'b1}}};

  logic [5:0]          s_exp;
  logic                has_one;
  logic [3:0]          kind;
  logic                live;
  logic [6:0]          sh_cmp;
  logic [6:0]          sh_idx;
  logic [XLEN-1:0]     cmp_mask;
  logic [XLEN-1:0]     keep_mask;
  logic [SUB_BITS-1:0] sub;
  logic                a_bit;
  logic                w_bit;

  // Size exponent: zero run from bit 12 up to the lowest set bit.
  always_comb begin
    s_exp   = '0;
    has_one = 1'b0;
    for (int b = XLEN - 1; b >= NAPOT_LSB; b--) begin
      if (ent.match[b]) begin
        s_exp   = 6'(b - NAPOT_LSB);
        has_one = 1'b1;
      end
    end
  end

  always_comb begin
    kind      = ent.match[3:0];
    live      = has_one && (kind != KIND_OFF) && (kind <= KIND_GEN_TRAP);
    sh_cmp    = 7'(s_exp) + 7'(NAPOT_LSB + 1);
    sh_idx    = 7'(s_exp) + 7'(NAPOT_LSB);
    cmp_mask  = VA_MASK & ({XLEN{1'b1}} << sh_cmp);
    keep_mask = TOP_CLEAR & ({XLEN{1'b1}} << sh_idx);
    hit       = live && (((addr ^ ent.match) & cmp_mask) == '0);
    sub       = SUB_BITS'(addr >> sh_idx);
    a_bit     = ((kind == KIND_ACC) || (kind == KIND_BOTH)) && ent.acc[sub];
    w_bit     = ((kind == KIND_WR)  || (kind == KIND_BOTH)) && ent.wr[sub];
    code      = hit ? {w_bit, a_bit} : RC_NONE;
    test_body = hit ? ((addr & keep_mask) | {52'd0, ent.match[11:4], 4'd0}) : '0;
  end

endmodule

// File: rtl/arc_first_hit.sv
module arc_first_hit #(
  parameter int NUM_ENTRIES = 8
) (
  input  logic [NUM_ENTRIES-1:0] hit_vec,
  output logic [NUM_ENTRIES-1:0] grant,
  output logic                   any_hit
);

  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (hit_vec[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
    any_hit = taken;
  end

endmodule

// File: rtl/addr_restrict_check.sv
module addr_restrict_check
  import arc_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int VAW         = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_entry,
  input  logic [2:0]       cfg_reg,
  input  logic [63:0]      cfg_wdata,
  input  logic             req_valid,
  input  logic [63:0]      req_addr,
  input  logic             req_is_store,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [1:0]       rsp_code,
  output logic             rsp_deny,
  output logic [63:0]      rsp_test
);

  entry_t [NUM_ENTRIES-1:0]            entries;
  logic   [NUM_ENTRIES-1:0]            hit_v;
  logic   [NUM_ENTRIES-1:0]            grant_vec;
  logic   [NUM_ENTRIES-1:0][1:0]       code_v;
  logic   [NUM_ENTRIES-1:0][XLEN-1:0]  body_v;
  logic                                any_hit;

  arc_entry_bank #(.NUM_ENTRIES(NUM_ENTRIES)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_entry (cfg_entry),
    .cfg_reg   (cfg_reg),
    .cfg_wdata (cfg_wdata),
    .entries_o (entries)
  );

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
    arc_entry_match #(.VAW(VAW)) u_cmp (
      .ent       (entries[e]),
      .addr      (req_addr),
      .hit       (hit_v[e]),
      .code      (code_v[e]),
      .test_body (body_v[e])
    );
  end

  arc_first_hit #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
    .hit_vec (hit_v),
    .grant   (grant_vec),
    .any_hit (any_hit)
  );

  // Next-state: AND-OR selection by the one-hot grant.
  logic [1:0]      code_d;
  logic [XLEN-1:0] body_d;
  logic            deny_d;
  logic            valid_d;
  logic            data_en;
  logic [XLEN-1:0] test_d;

  always_comb begin
    code_d = '0;
    body_d = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      code_d = code_d | (code_v[i] & {2{grant_vec[i]}});
      body_d = body_d | (body_v[i] & {XLEN{grant_vec[i]}});
    end
    case (code_d)
      RC_NONE:  deny_d = 1'b0;
      RC_ALL:   deny_d = 1'b1;
      RC_STORE: deny_d = req_is_store;
      default:  deny_d = 1'b1;
    endcase
    test_d  = body_d | {deny_d, {(XLEN-1){1'b0}}};
    valid_d = req_valid;
    data_en = req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit  <= 1'b0;
      rsp_code <= '0;
      rsp_deny <= 1'b0;
      rsp_test <= '0;
    end else if (data_en) begin
      rsp_hit  <= any_hit;
      rsp_code <= code_d;
      rsp_deny <= deny_d;
      rsp_test <= test_d;
    end
  end

endmodule

// File: rtl/addr_restrict_check_sva.sv
module addr_restrict_check_sva #(
  parameter int NUM_ENTRIES = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_is_store,
  input logic                   rsp_valid,
  input logic                   rsp_hit,
  input logic [1:0]             rsp_code,
  input logic                   rsp_deny,
  input logic [63:0]            rsp_test,
  input logic [NUM_ENTRIES-1:0] grant_vec,
  input logic [NUM_ENTRIES-1:0] hit_v
);

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R2
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R2
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_hit) |-> (rsp_code == 2'b00 && !rsp_deny && rsp_test == 64'd0)); // R7
  AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> (rsp_test[63] == rsp_deny)); // R8
  AST_FULL_DENY: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_code == 2'b01) |-> rsp_deny); // R5
  AST_LOAD_PASSES: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !req_is_store) |=> (rsp_code != 2'b10 || !rsp_deny)); // R5
  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant_vec)); // R7
  AST_WINNER_HIT: assert property (@(posedge clk) disable iff (!rst_n) (grant_vec & ~hit_v) == '0); // R7

endmodule

bind addr_restrict_check addr_restrict_check_sva #(.NUM_ENTRIES(NUM_ENTRIES)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_is_store (req_is_store),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_code     (rsp_code),
  .rsp_deny     (rsp_deny),
  .rsp_test     (rsp_test),
  .grant_vec    (grant_vec),
  .hit_v        (hit_v)
);

// File: tb/addr_restrict_check_test.sv
module addr_restrict_check_test;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_entry;
  logic [2:0]  cfg_reg;
  logic [63:0] cfg_wdata;
  logic        req_valid;
  logic [63:0] req_addr;
  logic        req_is_store;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [1:0]  rsp_code;
  logic        rsp_deny;
  logic [63:0] rsp_test;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  addr_restrict_check uut (
    .clk (clk), .rst_n (rst_n),
    .cfg_we (cfg_we), .cfg_entry (cfg_entry), .cfg_reg (cfg_reg), .cfg_wdata (cfg_wdata),
    .req_valid (req_valid), .req_addr (req_addr), .req_is_store (req_is_store),
    .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_code (rsp_code),
    .rsp_deny (rsp_deny), .rsp_test (rsp_test)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Region constants
  localparam logic [63:0] BASE_A = 64'h0000_1234_0060_0000;
  localparam logic [63:0] BASE_C = 64'h0000_1234_0020_0000;
  localparam logic [63:0] BASE_B = 64'h0000_00AB_C000_0000;
  localparam logic [63:0] EA1    = 64'h0000_1234_0061_0ABC;
  localparam logic [63:0] EA0    = 64'h0000_1234_0060_0ABC;
  localparam logic [63:0] EAB    = 64'h0000_00AB_C000_1234;

  function automatic logic [63:0] mk(input logic [63:0] base, input int s,
                                     input logic [5:0] rsw, input logic [1:0] gen,
                                     input logic [3:0] typ);
    return (base & ~((64'd1 << (13 + s)) - 64'd1)) | (64'd1 << (12 + s)) | {52'd0, rsw, gen, typ};
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] ent, input logic [2:0] sel, input logic [63:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_entry = ent; cfg_reg = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input string tag, input logic [63:0] addr, input logic st,
                      input logic e_hit, input logic [1:0] e_code, input logic e_deny,
                      input logic [63:0] e_test);
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_is_store = st;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " hit"},   64'(rsp_hit),   64'(e_hit));
    chk({tag, " code"},  64'(rsp_code),  64'(e_code));
    chk({tag, " deny"},  64'(rsp_deny),  64'(e_deny));
    chk({tag, " test"},  rsp_test,       e_test);
  endtask

  task automatic t_reset;
    chk("R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 reset rsp_test", rsp_test, 64'd0);
    look("R1 lookup after reset", EA1, 1'b0, 1'b0, 2'b00, 1'b0, 64'd0);
  endtask

  task automatic t_ignored_entries;
    cfg_write(4'd1, 3'd0, mk(BASE_B, 0, 6'd0, 2'd1, 4'd7));
    look("R9 reserved type disables", EAB, 1'b0, 1'b0, 2'b00, 1'b0, 64'd0);
    cfg_write(4'd9, 3'd0, 64'h8000_0000_0000_0001);
    look("R11 entry index out of range", EAB, 1'b0, 1'b0, 2'b00, 1'b0, 64'd0);
    cfg_write(4'd0, 3'd6, 64'h8000_0000_0000_0001);
    look("R11 bad register select", EAB, 1'b0, 1'b0, 2'b00, 1'b0, 64'd0);
    cfg_write(4'd4, 3'd1, '1);
    cfg_write(4'd4, 3'd0, 64'h0000_0000_0000_0001);
    look("R3 no napot bit never matches", 64'd0, 1'b0, 1'b0, 2'b00, 1'b0, 64'd0);
    cfg_write(4'd6, 3'd0, mk(BASE_B, 0, 6'd0, 2'd0, 4'd0));
    look("R6 type 0 disabled", EAB, 1'b0, 1'b0, 2'b00, 1'b0, 64'd0);
  endtask

  task automatic t_basic_access;
    cfg_write(4'd0, 3'd0, mk(BASE_A, 4, 6'h2A, 2'd2, 4'd1));
    cfg_write(4'd0, 3'd2, 64'd1 << 33);
    look("R4 index 97 access denied", EA1, 1'b0, 1'b1, 2'b01, 1'b1, 64'h8000_1234_0061_0AA0);
    look("R4 index 96 allowed", EA0, 1'b0, 1'b1, 2'b00, 1'b0, 64'h0000_1234_0060_0AA0);
    look("R3 bit 17 differs misses", EA1 ^ (64'd1 << 17), 1'b0, 1'b0, 2'b00, 1'b0, 64'd0);
    look("R3 bits above VAW ignored R8 in place", EA1 | (64'd1 << 50), 1'b0, 1'b1, 2'b01, 1'b1,
         64'h8004_1234_0061_0AA0);
    cfg_write(4'd2, 3'd0, mk(BASE_C, 4, 6'd0, 2'd0, 4'd1));
    cfg_write(4'd2, 3'd1, 64'd1 << 33);
    look("R4 low word index 33", 64'h0000_1234_0021_0000, 1'b0, 1'b1, 2'b01, 1'b1, 64'h8000_1234_0021_0000);
    look("R4 low word index 32", 64'h0000_1234_0020_0000, 1'b0, 1'b1, 2'b00, 1'b0, 64'h0000_1234_0020_0000);
  endtask

  task automatic t_type_masks;
    cfg_write(4'd0, 3'd4, 64'd1 << 32);
    look("R6 type 1 ignores store vector", EA0, 1'b1, 1'b1, 2'b00, 1'b0, 64'h0000_1234_0060_0AA0);
    cfg_write(4'd0, 3'd0, mk(BASE_A, 4, 6'h2A, 2'd2, 4'd3));
    look("R5 store-only code lets load pass", EA0, 1'b0, 1'b1, 2'b10, 1'b0, 64'h0000_1234_0060_0AA0);
    look("R5 store-only code denies store", EA0, 1'b1, 1'b1, 2'b10, 1'b1, 64'h8000_1234_0060_0AA0);
    look("R5 code 01 denies store", EA1, 1'b1, 1'b1, 2'b01, 1'b1, 64'h8000_1234_0061_0AA0);
    cfg_write(4'd0, 3'd0, mk(BASE_A, 4, 6'h2A, 2'd2, 4'd2));
    look("R6 type 2 ignores access vector", EA1, 1'b0, 1'b1, 2'b00, 1'b0, 64'h0000_1234_0061_0AA0);
    look("R6 type 2 uses store vector", EA0, 1'b1, 1'b1, 2'b10, 1'b1, 64'h8000_1234_0060_0AA0);
    cfg_write(4'd0, 3'd0, mk(BASE_A, 4, 6'h2A, 2'd2, 4'd3));
    cfg_write(4'd0, 3'd4, (64'd1 << 32) | (64'd1 << 33));
    look("R5 reserved code 11 denies load", EA1, 1'b0, 1'b1, 2'b11, 1'b1, 64'h8000_1234_0061_0AA0);
    cfg_write(4'd0, 3'd4, 64'd1 << 32);
    cfg_write(4'd3, 3'd1, '1);
    cfg_write(4'd3, 3'd0, mk(BASE_B, 0, 6'd0, 2'd1, 4'd4));
    look("R6 type 4 hits with code 00", EAB, 1'b1, 1'b1, 2'b00, 1'b0, 64'h0000_00AB_C000_1010);
  endtask

  task automatic t_priority;
    cfg_write(4'd5, 3'd1, 64'd1);
    cfg_write(4'd5, 3'd0, 64'h8000_0000_0000_0031);
    look("R10 match-all index 0", 64'h0000_0055_0000_0000, 1'b0, 1'b1, 2'b01, 1'b1, 64'h8000_0000_0000_0030);
    look("R10 match-all index 1", 64'h8000_0055_0000_0000, 1'b0, 1'b1, 2'b00, 1'b0, 64'h0000_0000_0000_0030);
    look("R7 entry 3 beats entry 5", EAB, 1'b0, 1'b1, 2'b00, 1'b0, 64'h0000_00AB_C000_1010);
    look("R7 entry 0 beats entry 5", EA0, 1'b0, 1'b1, 2'b10, 1'b0, 64'h0000_1234_0060_0AA0);
  endtask

  task automatic t_pipeline;
    @(negedge clk);
    req_valid = 1'b1; req_addr = EA1; req_is_store = 1'b0;
    @(negedge clk);
    req_addr = EAB;
    chk("R2 first of pair valid", 64'(rsp_valid), 64'd1);
    chk("R2 first of pair test", rsp_test, 64'h8000_1234_0061_0AA0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 second of pair valid", 64'(rsp_valid), 64'd1);
    chk("R2 second of pair test", rsp_test, 64'h0000_00AB_C000_1010);
    @(negedge clk);
    chk("R2 idle gives no valid", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_entry = '0; cfg_reg = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; req_is_store = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ignored_entries();
    t_basic_access();
    t_type_masks();
    t_priority();
    t_pipeline();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule